// File: doc/BRIEF.md
# I/O Translation Unit Configuration Register Bank

This block is the software-visible register bank of an I/O address-translation unit. A host bus reaches it with word-sized accesses: an address, separate write and read strobes, write data and a combinational read-data return. Each register keeps only its writable bits. Some bits are forced to fixed values, and the control register carries a fixed implementation/version byte that is set by a parameter. The bank does not walk page tables and does not arbitrate. It only holds the bits that those engines consume.

Two values go straight to the translator. One is the translation enable. The other is the start address of the translation window, which is decoded from a 3-bit range code. The window always ends at the top of the 32-bit space. When the translation engine reports a fault, the bank captures a fixed status word and the faulting address, and it raises a level interrupt. Software clears the interrupt by touching either fault register.

Writes to offsets that have no named register go to a small parameter-sized spare array, or they are dropped if that array does not cover the offset.

Top module: `xlat_cfg_bank`

## Requirements
- R1: After reset the registers hold these values: control = {VERSION, 24'h0}, table base = 0, fault status = 0x00800000, fault address = 0, arbiter enable = 0x00000003, bus arbitration enable = 0x00000008, mask ID = 0x23000000, slot configs, flush registers and spare words = 0. The interrupt is low.
- R2: The control register is at offset 0x0000. A write keeps only the bits under mask 0x0000001D. Bits 31:24 always read as the VERSION parameter.
- R3: Control bit 0 drives xlatEnable. The range code in control bits 4:2 selects winStart = 0xFFFFFFFF shifted left by (24 + code): code 0 gives 0xFF000000 and code 7 gives 0x80000000.
- R4: The table base register is at offset 0x0004 and keeps mask 0x07FFFC00. The four slot configuration registers are at 0x1010, 0x1014, 0x1018 and 0x101C, and each keeps mask 0x00010003.
- R5: The arbiter enable register is at offset 0x1008. It keeps mask 0x801F000F and bit 0 always reads 1.
- R6: The fault status register is at 0x1000. A bus write keeps mask 0xFF0FFFFF and forces bit 23 to 1. The fault address register is at 0x1004 and stores all 32 bits.
- R7: The bus arbitration enable register is at 0x2000. It keeps mask 0x001F0000 and bit 3 always reads 1.
- R8: A write to the mask ID register at 0x3018 ORs (data & 0x00FFFFFF) into its current value. Bits are never cleared by a write.
- R9: When capValid is high, the next cycle shows fault status = 0xC0820000, or 0xC0860000 if capIsRead is high, fault address = capAddr, and irq high. A capture overrides a bus write to either fault register in the same cycle.
- R10: A bus read or write of the fault status or fault address register, with no capture in the same cycle, drops irq in the next cycle.
- R11: The flush registers at 0x0014 and 0x0018 store all 32 bits of a write.
- R12: At an offset with no named register whose word index is below SPARE_DEPTH, writes are stored unmasked and read back. Any other unlisted offset ignores writes and reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the access; bits 1:0 are ignored |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe (a fault register read clears irq) |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| capValid | input | 1 | Fault capture request from the translation engine |
| capAddr | input | 32 | Faulting address to capture |
| capIsRead | input | 1 | The faulting access was a read |
| winStart | output | 32 | First address of the translation window |
| xlatEnable | output | 1 | Translation enable bit |
| irq | output | 1 | Level fault interrupt |

## Verification
The bench builds the bank with VERSION = 8'h5C and SPARE_DEPTH = 8. A non-zero version byte shows that the forced top byte survives every write. With a spare depth of 8, the unnamed offsets 0x0008, 0x000C and 0x001C are stored, while 0x0020 and 0x100C fall outside the array and must read zero. Random traffic over named and unnamed offsets, including captures that land in the same cycle as a write to the fault registers, is compared against a bench model of every mask and forced bit.

// File: rtl/xcb_pkg.sv
package xcb_pkg;

  localparam int NUM_SLOTS = 4;

  localparam logic [31:0] CTRL_KEEP   = 32'h0000_001D;
  localparam logic [31:0] BASE_KEEP   = 32'h07FF_FC00;
  localparam logic [31:0] AER_KEEP    = 32'h801F_000F;
  localparam logic [31:0] AER_FORCE   = 32'h0000_0001;
  localparam logic [31:0] AER_RESET   = 32'h0000_0003;
  localparam logic [31:0] AFSR_KEEP   = 32'hFF0F_FFFF;
  localparam logic [31:0] AFSR_FORCE  = 32'h0080_0000;
  localparam logic [31:0] SLOT_KEEP   = 32'h0001_0003;
  localparam logic [31:0] ARBEN_KEEP  = 32'h001F_0000;
  localparam logic [31:0] ARBEN_FORCE = 32'h0000_0008;
  localparam logic [31:0] MASKID_KEEP = 32'h00FF_FFFF;
  localparam logic [31:0] MASKID_RST  = 32'h2300_0000;
  // captured status: error, late error, reserved-one, address valid
  localparam logic [31:0] FAULT_WORD  = 32'hC082_0000;
  localparam logic [31:0] FAULT_RD    = 32'h0004_0000;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CTRL, SEL_BASE, SEL_TLBF, SEL_PGF, SEL_AFSR, SEL_AFAR,
    SEL_AER, SEL_SLOT, SEL_ARBEN, SEL_MASKID, SEL_SPARE
  } xcb_sel_e;

  typedef struct packed {
    logic       wrCtrl;
    logic       wrBase;
    logic       wrTlbf;
    logic       wrPgf;
    logic       wrAfsr;
    logic       wrAfar;
    logic       wrAer;
    logic       wrSlot;
    logic       wrArben;
    logic       wrMaskId;
    logic       wrSpare;
    logic       touchFault;
    logic [1:0] slotIdx;
  } xcb_strobe_t;

  function automatic logic [31:0] winFromCode(input logic [2:0] code);
    return 32'hFFFF_FFFF << (24 + int'(code));
  endfunction

endpackage

// File: rtl/xcb_decode.sv
module xcb_decode
  import xcb_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int SPARE_DEPTH = 8,
  localparam int WORD_W     = ADDR_W - 2,
  localparam int SPW        = (SPARE_DEPTH > 1) ? $clog2(SPARE_DEPTH) : 1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output xcb_strobe_t       stb,
  output xcb_sel_e          rdSel,
  output logic [SPW-1:0]    spareIdx
);

  localparam logic [WORD_W-1:0] IDX_CTRL   = WORD_W'(12'h000);
  localparam logic [WORD_W-1:0] IDX_BASE   = WORD_W'(12'h001);
  localparam logic [WORD_W-1:0] IDX_TLBF   = WORD_W'(12'h005);
  localparam logic [WORD_W-1:0] IDX_PGF    = WORD_W'(12'h006);
  localparam logic [WORD_W-1:0] IDX_AFSR   = WORD_W'(12'h400);
  localparam logic [WORD_W-1:0] IDX_AFAR   = WORD_W'(12'h401);
  localparam logic [WORD_W-1:0] IDX_AER    = WORD_W'(12'h402);
  localparam logic [WORD_W-1:0] IDX_SLOT0  = WORD_W'(12'h404);
  localparam logic [WORD_W-1:0] IDX_SLOT1  = WORD_W'(12'h405);
  localparam logic [WORD_W-1:0] IDX_SLOT2  = WORD_W'(12'h406);
  localparam logic [WORD_W-1:0] IDX_SLOT3  = WORD_W'(12'h407);
  localparam logic [WORD_W-1:0] IDX_ARBEN  = WORD_W'(12'h800);
  localparam logic [WORD_W-1:0] IDX_MASKID = WORD_W'(12'hC06);

  logic [WORD_W-1:0] wordIdx;
  logic [1:0]        unusedLowBits;

  assign wordIdx       = busAddr[ADDR_W-1:2];
  assign unusedLowBits = busAddr[1:0];
  assign spareIdx      = wordIdx[SPW-1:0];

  always_comb begin
    case (wordIdx)
      IDX_CTRL:   rdSel = SEL_CTRL;
      IDX_BASE:   rdSel = SEL_BASE;
      IDX_TLBF:   rdSel = SEL_TLBF;
      IDX_PGF:    rdSel = SEL_PGF;
      IDX_AFSR:   rdSel = SEL_AFSR;
      IDX_AFAR:   rdSel = SEL_AFAR;
      IDX_AER:    rdSel = SEL_AER;
      IDX_SLOT0, IDX_SLOT1, IDX_SLOT2, IDX_SLOT3: rdSel = SEL_SLOT;
      IDX_ARBEN:  rdSel = SEL_ARBEN;
      IDX_MASKID: rdSel = SEL_MASKID;
      default:    rdSel = (int'(wordIdx) < SPARE_DEPTH) ? SEL_SPARE : SEL_NONE;
    endcase
  end

  always_comb begin
    stb            = '0;
    stb.wrCtrl     = busWe && (rdSel == SEL_CTRL);
    stb.wrBase     = busWe && (rdSel == SEL_BASE);
    stb.wrTlbf     = busWe && (rdSel == SEL_TLBF);
    stb.wrPgf      = busWe && (rdSel == SEL_PGF);
    stb.wrAfsr     = busWe && (rdSel == SEL_AFSR);
    stb.wrAfar     = busWe && (rdSel == SEL_AFAR);
    stb.wrAer      = busWe && (rdSel == SEL_AER);
    stb.wrSlot     = busWe && (rdSel == SEL_SLOT);
    stb.wrArben    = busWe && (rdSel == SEL_ARBEN);
    stb.wrMaskId   = busWe && (rdSel == SEL_MASKID);
    stb.wrSpare    = busWe && (rdSel == SEL_SPARE);
    stb.touchFault = (busWe || busRe) && ((rdSel == SEL_AFSR) || (rdSel == SEL_AFAR));
    stb.slotIdx    = wordIdx[1:0];
  end

endmodule

// File: rtl/xcb_regs.sv
module xcb_regs
  import xcb_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'h00,
  parameter int SPARE_DEPTH     = 8,
  localparam int SPW            = (SPARE_DEPTH > 1) ? $clog2(SPARE_DEPTH) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  xcb_strobe_t    stb,
  input  xcb_sel_e       rdSel,
  input  logic [SPW-1:0] spareIdx,
  input  logic [31:0]    busWdata,
  input  logic           capValid,
  input  logic [31:0]    capAddr,
  input  logic           capIsRead,
  output logic [31:0]    busRdata,
  output logic [31:0]    winStart,
  output logic           xlatEnable,
  output logic           irq
);

  localparam logic [31:0] VER_WORD = {VERSION, 24'h0};

  logic [31:0] ctrlReg, baseReg, tlbfReg, pgfReg, afsrReg, afarReg;
  logic [31:0] aerReg, arbenReg, maskIdReg, spareRd;
  logic [31:0] slotReg [NUM_SLOTS];
  logic        irqReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= VER_WORD;
      baseReg   <= '0;
      tlbfReg   <= '0;
      pgfReg    <= '0;
      afsrReg   <= AFSR_FORCE;
      afarReg   <= '0;
      aerReg    <= AER_RESET;
      arbenReg  <= ARBEN_FORCE;
      maskIdReg <= MASKID_RST;
      irqReg    <= 1'b0;
    end else begin
      if (stb.wrCtrl)   ctrlReg   <= (busWdata & CTRL_KEEP) | VER_WORD;
      if (stb.wrBase)   baseReg   <= busWdata & BASE_KEEP;
      if (stb.wrTlbf)   tlbfReg   <= busWdata;
      if (stb.wrPgf)    pgfReg    <= busWdata;
      if (stb.wrAer)    aerReg    <= (busWdata & AER_KEEP) | AER_FORCE;
      if (stb.wrArben)  arbenReg  <= (busWdata & ARBEN_KEEP) | ARBEN_FORCE;
      if (stb.wrMaskId) maskIdReg <= maskIdReg | (busWdata & MASKID_KEEP);
      if (capValid) begin
        afsrReg <= FAULT_WORD | (capIsRead ? FAULT_RD : 32'h0);
        afarReg <= capAddr;
      end else begin
        if (stb.wrAfsr) afsrReg <= (busWdata & AFSR_KEEP) | AFSR_FORCE;
        if (stb.wrAfar) afarReg <= busWdata;
      end
      if (capValid)            irqReg <= 1'b1;
      else if (stb.touchFault) irqReg <= 1'b0;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN)
        slotReg[s] <= '0;
      else if (stb.wrSlot && (int'(stb.slotIdx) == s))
        slotReg[s] <= busWdata & SLOT_KEEP;
    end
  end

  if (SPARE_DEPTH > 0) begin : g_spare
    logic [31:0] spareMem [SPARE_DEPTH];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < SPARE_DEPTH; i++) spareMem[i] <= '0;
      end else if (stb.wrSpare) begin
        spareMem[spareIdx] <= busWdata;
      end
    end
    assign spareRd = spareMem[spareIdx];
  end else begin : g_nospare
    logic [SPW-1:0] unusedIdx;
    assign unusedIdx = spareIdx;
    assign spareRd   = '0;
  end

  always_comb begin
    case (rdSel)
      SEL_CTRL:   busRdata = ctrlReg;
      SEL_BASE:   busRdata = baseReg;
      SEL_TLBF:   busRdata = tlbfReg;
      SEL_PGF:    busRdata = pgfReg;
      SEL_AFSR:   busRdata = afsrReg;
      SEL_AFAR:   busRdata = afarReg;
      SEL_AER:    busRdata = aerReg;
      SEL_SLOT:   busRdata = slotReg[stb.slotIdx];
      SEL_ARBEN:  busRdata = arbenReg;
      SEL_MASKID: busRdata = maskIdReg;
      SEL_SPARE:  busRdata = spareRd;
      default:    busRdata = '0;
    endcase
  end

  assign winStart   = winFromCode(ctrlReg[4:2]);
  assign xlatEnable = ctrlReg[0];
  assign irq        = irqReg;

  a_r9_capture_raises_irq: assert property (@(posedge clk) disable iff (!rstN)
    capValid |=> irqReg);

  a_r9_capture_status: assert property (@(posedge clk) disable iff (!rstN)
    capValid |=> (afsrReg[31] && afsrReg[17] && afsrReg[23] && afarReg == $past(capAddr)));

  a_r10_touch_clears_irq: assert property (@(posedge clk) disable iff (!rstN)
    (stb.touchFault && !capValid) |=> !irqReg);

  a_r8_maskid_keeps_bits: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((maskIdReg & $past(maskIdReg)) == $past(maskIdReg)));

endmodule

// File: rtl/xlat_cfg_bank.sv
module xlat_cfg_bank
  import xcb_pkg::*;
#(
  parameter logic [7:0] VERSION = 8'h00,
  parameter int SPARE_DEPTH     = 8,
  parameter int ADDR_W          = 14,
  localparam int SPW            = (SPARE_DEPTH > 1) ? $clog2(SPARE_DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              capValid,
  input  logic [31:0]       capAddr,
  input  logic              capIsRead,
  output logic [31:0]       winStart,
  output logic              xlatEnable,
  output logic              irq
);

  xcb_strobe_t    stb;
  xcb_sel_e       rdSel;
  logic [SPW-1:0] spareIdx;

  xcb_decode #(.ADDR_W(ADDR_W), .SPARE_DEPTH(SPARE_DEPTH)) u_decode (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .stb     (stb),
    .rdSel   (rdSel),
    .spareIdx(spareIdx)
  );

  xcb_regs #(.VERSION(VERSION), .SPARE_DEPTH(SPARE_DEPTH)) u_regs (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .rdSel     (rdSel),
    .spareIdx  (spareIdx),
    .busWdata  (busWdata),
    .capValid  (capValid),
    .capAddr   (capAddr),
    .capIsRead (capIsRead),
    .busRdata  (busRdata),
    .winStart  (winStart),
    .xlatEnable(xlatEnable),
    .irq       (irq)
  );

endmodule

// File: tb/sim_xlat_cfg_bank.sv
`timescale 1ns/1ps
module sim_xlat_cfg_bank;

  localparam logic [7:0] VER = 8'h5C;
  localparam int SPD = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [13:0] busAddr = '0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        capValid = 1'b0, capIsRead = 1'b0;
  logic [31:0] capAddr = '0;
  logic [31:0] winStart;
  logic        xlatEnable, irq;

  int vectors = 0, fails = 0, cyc = 0;
  bit inReset = 1'b0;

  logic [31:0] mCtrl, mBase, mTlbf, mPgf, mAfsr, mAfar, mAer, mArben, mMask;
  logic [31:0] mSlot [4];
  logic [31:0] mSpare [SPD];
  logic        mIrq;

  always #10 clk = ~clk;

  xlat_cfg_bank #(.VERSION(VER), .SPARE_DEPTH(SPD), .ADDR_W(14)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .capValid(capValid),
    .capAddr(capAddr), .capIsRead(capIsRead), .winStart(winStart),
    .xlatEnable(xlatEnable), .irq(irq)
  );

  function automatic bit isNamed(input logic [13:0] off);
    case (off)
      14'h0000, 14'h0004, 14'h0014, 14'h0018, 14'h1000, 14'h1004, 14'h1008,
      14'h1010, 14'h1014, 14'h1018, 14'h101C, 14'h2000, 14'h3018: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tagOf(input logic [13:0] off);
    case (off)
      14'h0000: return "R2";
      14'h0004, 14'h1010, 14'h1014, 14'h1018, 14'h101C: return "R4";
      14'h0014, 14'h0018: return "R11";
      14'h1000, 14'h1004: return "R6";
      14'h1008: return "R5";
      14'h2000: return "R7";
      14'h3018: return "R8";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [31:0] expWin(input logic [2:0] code);
    logic [31:0] w;
    w = 32'hFFFF_FFFF;
    for (int i = 0; i < 24 + int'(code); i++) w = {w[30:0], 1'b0};
    return w;
  endfunction

  function automatic logic [31:0] modelRead(input logic [13:0] off);
    case (off)
      14'h0000: return mCtrl;
      14'h0004: return mBase;
      14'h0014: return mTlbf;
      14'h0018: return mPgf;
      14'h1000: return mAfsr;
      14'h1004: return mAfar;
      14'h1008: return mAer;
      14'h1010: return mSlot[0];
      14'h1014: return mSlot[1];
      14'h1018: return mSlot[2];
      14'h101C: return mSlot[3];
      14'h2000: return mArben;
      14'h3018: return mMask;
      default: return (int'(off >> 2) < SPD) ? mSpare[off >> 2] : 32'h0;
    endcase
  endfunction

  task automatic modelReset();
    mCtrl = {VER, 24'h0}; mBase = 0; mTlbf = 0; mPgf = 0;
    mAfsr = 32'h0080_0000; mAfar = 0; mAer = 32'h3; mArben = 32'h8;
    mMask = 32'h2300_0000; mIrq = 1'b0;
    for (int i = 0; i < 4; i++) mSlot[i] = 0;
    for (int i = 0; i < SPD; i++) mSpare[i] = 0;
  endtask

  task automatic modelWrite(input logic [13:0] off, input logic [31:0] v);
    case (off)
      14'h0000: mCtrl = (v & 32'h1D) | {VER, 24'h0};
      14'h0004: mBase = v & 32'h07FF_FC00;
      14'h0014: mTlbf = v;
      14'h0018: mPgf = v;
      14'h1000: mAfsr = (v & 32'hFF0F_FFFF) | 32'h0080_0000;
      14'h1004: mAfar = v;
      14'h1008: mAer = (v & 32'h801F_000F) | 32'h1;
      14'h1010: mSlot[0] = v & 32'h0001_0003;
      14'h1014: mSlot[1] = v & 32'h0001_0003;
      14'h1018: mSlot[2] = v & 32'h0001_0003;
      14'h101C: mSlot[3] = v & 32'h0001_0003;
      14'h2000: mArben = (v & 32'h001F_0000) | 32'h8;
      14'h3018: mMask = mMask | (v & 32'h00FF_FFFF);
      default: if (!isNamed(off) && int'(off >> 2) < SPD) mSpare[off >> 2] = v;
    endcase
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  // drive at negedge, sample 1 ns later, update model after posedge
  task automatic step(input bit we, input bit re, input logic [13:0] off,
                      input logic [31:0] wd, input bit cap, input bit capRd,
                      input logic [31:0] ca);
    bit touch;
    busWe = we; busRe = re; busAddr = off; busWdata = wd;
    capValid = cap; capIsRead = capRd; capAddr = ca;
    #1;
    if (re) check(inReset ? "R1" : tagOf(off), busRdata, modelRead(off));
    check(cap ? "R9" : "R10", {31'h0, irq}, {31'h0, mIrq});
    check("R3", winStart, expWin(mCtrl[4:2]));
    check("R3", {31'h0, xlatEnable}, {31'h0, mCtrl[0]});
    @(posedge clk);
    touch = (we || re) && (off == 14'h1000 || off == 14'h1004);
    if (we) modelWrite(off, wd);
    if (cap) begin
      mAfsr = 32'hC082_0000 | (capRd ? 32'h0004_0000 : 32'h0);
      mAfar = ca;
    end
    if (cap) mIrq = 1'b1;
    else if (touch) mIrq = 1'b0;
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  logic [13:0] offs [18];

  initial begin
    logic [13:0] o;
    int unsigned r;
    offs = '{14'h0000, 14'h0004, 14'h0014, 14'h0018, 14'h1000, 14'h1004,
             14'h1008, 14'h1010, 14'h1014, 14'h1018, 14'h101C, 14'h2000,
             14'h3018, 14'h0008, 14'h000C, 14'h001C, 14'h0020, 14'h100C};
    r = $urandom(32'd2024);
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values of every offset
    inReset = 1'b1;
    for (int i = 0; i < 18; i++) step(0, 1, offs[i], 0, 0, 0, 0);
    inReset = 1'b0;
    // R3: all eight range codes with enable set
    for (int c = 0; c < 8; c++) begin
      step(1, 0, 14'h0000, 32'hFFFF_FFE0 | (32'(c) << 2) | 32'h1, 0, 0, 0);
      step(0, 1, 14'h0000, 0, 0, 0, 0);
    end
    step(1, 0, 14'h0000, 32'h0, 0, 0, 0);
    step(0, 1, 14'h0000, 0, 0, 0, 0);
    // R8: OR accumulation, no clearing
    step(1, 0, 14'h3018, 32'hFF00_00F0, 0, 0, 0);
    step(1, 0, 14'h3018, 32'h0000_0F00, 0, 0, 0);
    step(1, 0, 14'h3018, 32'h0, 0, 0, 0);
    step(0, 1, 14'h3018, 0, 0, 0, 0);
    // R9: capture beats same-cycle write, read variant
    step(1, 0, 14'h1000, 32'h0, 1, 1, 32'hF123_4000);
    step(0, 0, 14'h0000, 0, 0, 0, 0);
    step(0, 1, 14'h1000, 0, 0, 0, 0);
    step(0, 1, 14'h1004, 0, 0, 0, 0);
    // R9: capture beats write to fault address, write variant
    step(1, 0, 14'h1004, 32'h1111_1111, 1, 0, 32'hFE00_5000);
    step(0, 1, 14'h1004, 0, 0, 0, 0);
    step(0, 1, 14'h1000, 0, 0, 0, 0);
    // R10: write to fault status clears irq
    step(1, 0, 14'h0008, 32'hABCD_0001, 1, 0, 32'h1);
    step(1, 0, 14'h1000, 32'hFFFF_FFFF, 0, 0, 0);
    step(0, 1, 14'h1000, 0, 0, 0, 0);
    // R12: spare stored, out-of-array dropped
    step(0, 1, 14'h0008, 0, 0, 0, 0);
    step(1, 0, 14'h0020, 32'hDEAD_BEEF, 0, 0, 0);
    step(0, 1, 14'h0020, 0, 0, 0, 0);
    step(1, 0, 14'h100C, 32'h1234_5678, 0, 0, 0);
    step(0, 1, 14'h100C, 0, 0, 0, 0);
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = int'($urandom_range(0, 2));
      o  = offs[$urandom_range(0, 17)];
      step(op == 1, op == 2, o, $urandom, ($urandom_range(0, 7) == 0),
           $urandom_range(0, 1) == 1, $urandom);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule